// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block paces an RGB parallel display. From a source clock it derives a pixel tick through a programmable divider. On each tick it walks a horizontal counter through four segments, and on each line wrap it walks a vertical counter through the same four segments. It drives active-high horizontal and vertical sync, a data-enable, and the pixel coordinates inside the active area. Every width is programmed as its count minus one. The configuration is copied into shadow registers when scan-out starts and again at each frame boundary, so a change made mid-frame never disturbs the frame on screen.

The block also produces two events. A sticky frame status bit sets at the start of vertical sync when both a global and a frame interrupt enable are high; software clears it by writing one. A one-cycle line pulse marks the start of the active line whose index equals a threshold. The threshold is usually the last active line.

Top module: `vtg_top`

## Requirements
- R1: Each line runs through sync, back porch, active and front porch in that order. Each segment lasts its programmed value plus one pixel ticks. `hsync` is high only during the horizontal sync segment.
- R2: Each frame runs through sync, back porch, active and front porch lines in that order. Each segment lasts its programmed value plus one lines. `vsync` is high only during the vertical sync lines.
- R3: `de` is high only when both counters are in their active segments. `pix_x` and `pix_y` give the zero-based active column and row, and each reads 0 outside its active segment.
- R4: A pixel lasts `div_m1`+1 source clock cycles. The ratio saturates at 255, so a field value of 255 also gives 255 cycles. A value of 0 gives one tick every cycle.
- R5: `frame_sts` sets on the cycle a frame begins (vsync rises) only when `irq_glb_en` and `irq_frm_en` were both high before that edge. With either enable low it stays 0.
- R6: `frame_sts` holds until a cycle with `irq_clr` high clears it. If a set and a clear fall on the same edge, the set wins.
- R7: `line_hit` is high for exactly the first source cycle of the active line whose zero-based index equals `line_thr`.
- R8: Raising `vid_en` from idle starts a frame at the next edge. Lowering it stops scan-out only at the end of the current frame. While idle, all video outputs are 0.
- R9: Timing, divider and threshold inputs are captured at start and at each frame boundary. Changes made mid-frame take effect from the next frame.
- R10: After reset all outputs are 0 and `frame_sts` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_en | input | 1 | Scan-out enable |
| div_m1 | input | 8 | Pixel clock ratio minus one |
| hsw_m1 | input | 12 | Horizontal sync width minus one |
| hbp_m1 | input | 12 | Horizontal back porch minus one |
| hact_m1 | input | 12 | Active pixels per line minus one |
| hfp_m1 | input | 12 | Horizontal front porch minus one |
| vsw_m1 | input | 11 | Vertical sync lines minus one |
| vbp_m1 | input | 11 | Vertical back porch minus one |
| vact_m1 | input | 11 | Active lines minus one |
| vfp_m1 | input | 11 | Vertical front porch minus one |
| line_thr | input | 11 | Active line index that raises line_hit |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_frm_en | input | 1 | Frame interrupt enable |
| irq_clr | input | 1 | Write-one clear of frame_sts |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pix_x | output | 12 | Active column |
| pix_y | output | 11 | Active row |
| frame_sts | output | 1 | Sticky frame interrupt status |
| line_hit | output | 1 | Threshold line pulse |

## Verification
A corrupted segment counter or a misloaded shadow register shows up at once as a sync or data-enable edge one tick early or late. The per-cycle comparison reports it within the first line, or for vertical faults within the first frame. A divider fault stretches or shrinks every pixel, and the saturated-ratio run catches it through the length of the first hsync pulse. Faults in the status bit appear at the first frame start or the first clear strobe. A premature stop or a missed reload appears at the next frame boundary.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_ACT   = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;

    // Segment succession within a line or a frame.
    function automatic seg_e seg_after(input seg_e s);
        case (s)
            SEG_SYNC: return SEG_BACK;
            SEG_BACK: return SEG_ACT;
            SEG_ACT:  return SEG_FRONT;
            default:  return SEG_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/vtg_clkdiv.sv
module vtg_clkdiv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div_m1,
    output logic         tick
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};
    localparam logic [W-1:0] SAT  = ALL1 - 1'b1;

    logic [W-1:0] lim;
    logic [W-1:0] dcnt;

    assign lim  = (div_m1 == ALL1) ? SAT : div_m1;
    assign tick = run && (dcnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) dcnt <= '0;
        else                     dcnt <= dcnt + 1'b1;
    end

    assert_tick_restart_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (dcnt == '0));

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] sw_m1,
    input  logic [W-1:0] bp_m1,
    input  logic [W-1:0] act_m1,
    input  logic [W-1:0] fp_m1,
    output seg_e         seg,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output seg_e         nxt_seg,
    output logic [W-1:0] nxt_cnt
);
    logic [W-1:0] len;
    logic         at_end;

    always_comb begin
        case (seg)
            SEG_SYNC: len = sw_m1;
            SEG_BACK: len = bp_m1;
            SEG_ACT:  len = act_m1;
            default:  len = fp_m1;
        endcase
    end

    assign at_end = (cnt == len);
    assign wrap   = step && at_end && (seg == SEG_FRONT);

    always_comb begin
        nxt_seg = seg;
        nxt_cnt = cnt;
        if (step) begin
            if (at_end) begin
                nxt_seg = seg_after(seg);
                nxt_cnt = '0;
            end else begin
                nxt_cnt = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg <= SEG_SYNC;
            cnt <= '0;
        end else begin
            seg <= nxt_seg;
            cnt <= nxt_cnt;
        end
    end

    assert_cnt_in_seg_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= len);

    assert_seg_order_R1: assert property (@(posedge clk) disable iff (rst)
        (step && at_end) |=> (seg == seg_after($past(seg)) && cnt == '0));

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vid_en,
    input  logic [DW-1:0] div_m1,
    input  logic [HW-1:0] hsw_m1,
    input  logic [HW-1:0] hbp_m1,
    input  logic [HW-1:0] hact_m1,
    input  logic [HW-1:0] hfp_m1,
    input  logic [VW-1:0] vsw_m1,
    input  logic [VW-1:0] vbp_m1,
    input  logic [VW-1:0] vact_m1,
    input  logic [VW-1:0] vfp_m1,
    input  logic [VW-1:0] line_thr,
    input  logic          irq_glb_en,
    input  logic          irq_frm_en,
    input  logic          irq_clr,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [HW-1:0] pix_x,
    output logic [VW-1:0] pix_y,
    output logic          frame_sts,
    output logic          line_hit
);
    logic          run_q;
    logic [DW-1:0] div_s;
    logic [HW-1:0] hsw_s, hbp_s, hact_s, hfp_s;
    logic [VW-1:0] vsw_s, vbp_s, vact_s, vfp_s, thr_s;

    logic          tick;
    seg_e          h_seg, h_nseg, v_seg, v_nseg;
    logic [HW-1:0] h_cnt, h_ncnt;
    logic [VW-1:0] v_cnt, v_ncnt;
    logic          h_wrap, v_wrap;
    logic          start, reload, frame_evt;

    assign start     = !run_q && vid_en;
    assign reload    = start || (v_wrap && vid_en);
    assign frame_evt = reload;

    vtg_clkdiv #(.W(DW)) u_div (
        .clk(clk), .rst(rst), .run(run_q), .div_m1(div_s), .tick(tick)
    );

    vtg_axis #(.W(HW)) u_h (
        .clk(clk), .rst(rst), .step(tick),
        .sw_m1(hsw_s), .bp_m1(hbp_s), .act_m1(hact_s), .fp_m1(hfp_s),
        .seg(h_seg), .cnt(h_cnt), .wrap(h_wrap),
        .nxt_seg(h_nseg), .nxt_cnt(h_ncnt)
    );

    vtg_axis #(.W(VW)) u_v (
        .clk(clk), .rst(rst), .step(h_wrap),
        .sw_m1(vsw_s), .bp_m1(vbp_s), .act_m1(vact_s), .fp_m1(vfp_s),
        .seg(v_seg), .cnt(v_cnt), .wrap(v_wrap),
        .nxt_seg(v_nseg), .nxt_cnt(v_ncnt)
    );

    // Shadow capture at start and at each frame boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            div_s  <= '0;
            hsw_s  <= '0; hbp_s <= '0; hact_s <= '0; hfp_s <= '0;
            vsw_s  <= '0; vbp_s <= '0; vact_s <= '0; vfp_s <= '0;
            thr_s  <= '0;
        end else begin
            if (start)                    run_q <= 1'b1;
            else if (v_wrap && !vid_en)   run_q <= 1'b0;
            if (reload) begin
                div_s  <= div_m1;
                hsw_s  <= hsw_m1; hbp_s <= hbp_m1; hact_s <= hact_m1; hfp_s <= hfp_m1;
                vsw_s  <= vsw_m1; vbp_s <= vbp_m1; vact_s <= vact_m1; vfp_s <= vfp_m1;
                thr_s  <= line_thr;
            end
        end
    end

    // Frame status and threshold pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_sts <= 1'b0;
            line_hit  <= 1'b0;
        end else begin
            if (frame_evt && irq_glb_en && irq_frm_en) frame_sts <= 1'b1;
            else if (irq_clr)                         frame_sts <= 1'b0;
            line_hit <= h_wrap && (v_nseg == SEG_ACT) && (v_ncnt == thr_s);
        end
    end

    assign hsync = run_q && (h_seg == SEG_SYNC);
    assign vsync = run_q && (v_seg == SEG_SYNC);
    assign de    = run_q && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);
    assign pix_x = (run_q && h_seg == SEG_ACT) ? h_cnt : '0;
    assign pix_y = (run_q && v_seg == SEG_ACT) ? v_cnt : '0;

    assert_de_outside_sync_R3: assert property (@(posedge clk) disable iff (rst)
        de |-> (!hsync && !vsync));

    assert_sts_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_sts && !irq_clr) |=> frame_sts);

    assert_sts_at_vsync_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(vsync) && $past(irq_glb_en && irq_frm_en)) |-> frame_sts);

    assert_hit_line_start_R7: assert property (@(posedge clk) disable iff (rst)
        line_hit |-> hsync);

    assert_frame_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (run_q && !v_wrap) |=> run_q);

endmodule

// File: tb/vtg_top_tb.sv
module vtg_top_tb;

    typedef struct packed {
        logic        hs;
        logic        vs;
        logic        de;
        logic [11:0] x;
        logic [10:0] y;
        logic        lh;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vid_en = 1'b0;
    logic [7:0]  div_m1 = '0;
    logic [11:0] hsw_m1 = '0, hbp_m1 = '0, hact_m1 = '0, hfp_m1 = '0;
    logic [10:0] vsw_m1 = '0, vbp_m1 = '0, vact_m1 = '0, vfp_m1 = '0;
    logic [10:0] line_thr = '0;
    logic        irq_glb_en = 1'b0, irq_frm_en = 1'b0, irq_clr = 1'b0;
    logic        hsync, vsync, de, frame_sts, line_hit;
    logic [11:0] pix_x;
    logic [10:0] pix_y;

    int   checks = 0;
    int   failures = 0;
    bit   mon_on = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    vtg_top u_dut (
        .clk(clk), .rst(rst), .vid_en(vid_en), .div_m1(div_m1),
        .hsw_m1(hsw_m1), .hbp_m1(hbp_m1), .hact_m1(hact_m1), .hfp_m1(hfp_m1),
        .vsw_m1(vsw_m1), .vbp_m1(vbp_m1), .vact_m1(vact_m1), .vfp_m1(vfp_m1),
        .line_thr(line_thr), .irq_glb_en(irq_glb_en), .irq_frm_en(irq_frm_en),
        .irq_clr(irq_clr), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .frame_sts(frame_sts), .line_hit(line_hit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected per-cycle items for one frame (counts given as real lengths).
    task automatic push_frame(input int hs, input int hb, input int ha, input int hf,
                              input int vs, input int vb, input int va, input int vf,
                              input int thr, input int ratio);
        for (int l = 0; l < vs + vb + va + vf; l++) begin
            bit v_act = (l >= vs + vb) && (l < vs + vb + va);
            int vy    = v_act ? l - vs - vb : 0;
            for (int p = 0; p < hs + hb + ha + hf; p++) begin
                bit h_act = (p >= hs + hb) && (p < hs + hb + ha);
                int hx    = h_act ? p - hs - hb : 0;
                for (int r = 0; r < ratio; r++) begin
                    exp_t e;
                    e.hs = (p < hs);
                    e.vs = (l < vs);
                    e.de = h_act && v_act;
                    e.x  = 12'(hx);
                    e.y  = 11'(vy);
                    e.lh = (r == 0) && (p == 0) && v_act && (vy == thr);
                    q.push_back(e);
                end
            end
        end
    endtask

    // Monitor: compares one expected item per source cycle (R1 R2 R3 R4 R7 R8 R9).
    always @(negedge clk) begin
        if (mon_on && q.size() > 0) begin
            exp_t e;
            exp_t a;
            e = q.pop_front();
            a = {hsync, vsync, de, pix_x, pix_y, line_hit};
            check("R1/R2/R3/R7 scan", 32'(a), 32'(e));
        end
    end

    task automatic set_cfg(input int d, input int hs, input int hb, input int ha, input int hf,
                           input int vs, input int vb, input int va, input int vf, input int thr);
        div_m1  = 8'(d);
        hsw_m1  = 12'(hs - 1); hbp_m1 = 12'(hb - 1); hact_m1 = 12'(ha - 1); hfp_m1 = 12'(hf - 1);
        vsw_m1  = 11'(vs - 1); vbp_m1 = 11'(vb - 1); vact_m1 = 11'(va - 1); vfp_m1 = 11'(vf - 1);
        line_thr = 11'(thr);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vid_en = 1'b0; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hi_cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 outputs", 32'({hsync, vsync, de, pix_x, pix_y, frame_sts, line_hit}), 32'd0);

        // Frame A (ratio 1), then frame B (ratio 2) programmed mid-frame, then stop.
        set_cfg(0, 2, 2, 4, 1, 1, 1, 3, 2, 2);
        irq_glb_en = 1'b1; irq_frm_en = 1'b1;
        push_frame(2, 2, 4, 1, 1, 1, 3, 2, 2, 1);
        push_frame(1, 1, 3, 2, 2, 1, 2, 1, 1, 2);
        for (int i = 0; i < 6; i++) q.push_back('0);   // R8: idle after stop
        @(negedge clk);
        vid_en = 1'b1;
        @(posedge clk);
        mon_on = 1'b1;
        @(negedge clk);                       // N1
        check("R5 set at first vsync", 32'(frame_sts), 32'd1);
        irq_clr = 1'b1;
        @(negedge clk);                       // N2
        irq_clr = 1'b0;
        check("R6 write-one clear", 32'(frame_sts), 32'd0);
        repeat (18) @(negedge clk);           // N20
        set_cfg(1, 1, 1, 3, 2, 2, 1, 2, 1, 1); // R9: applies from next frame
        repeat (50) @(negedge clk);           // N70, inside frame B
        vid_en = 1'b0;                        // R8: stop at frame end
        check("R6 sticky across frame", 32'(frame_sts), 32'd1);
        wait (q.size() == 0);
        @(negedge clk);
        mon_on = 1'b0;
        check("R8 idle after stop", 32'({hsync, vsync, de}), 32'd0);

        // R10: reset clears a set status
        do_reset();
        @(negedge clk);
        check("R10 status cleared", 32'(frame_sts), 32'd0);

        // R6: set wins over a clear held high
        set_cfg(0, 2, 2, 4, 1, 1, 1, 3, 2, 2);
        irq_glb_en = 1'b1; irq_frm_en = 1'b1; irq_clr = 1'b1;
        vid_en = 1'b1;
        @(negedge clk);
        check("R6 set beats clear", 32'(frame_sts), 32'd1);
        @(negedge clk);
        check("R6 clear next cycle", 32'(frame_sts), 32'd0);

        // R5: frame enable low blocks the status
        do_reset();
        irq_glb_en = 1'b1; irq_frm_en = 1'b0;
        vid_en = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 frame enable low", 32'(frame_sts), 32'd0);
        // R5: global enable low blocks the status
        do_reset();
        irq_glb_en = 1'b0; irq_frm_en = 1'b1;
        vid_en = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 global enable low", 32'(frame_sts), 32'd0);

        // R4: field 255 saturates to ratio 255 (hsync 2 pixels = 510 cycles)
        do_reset();
        set_cfg(255, 2, 2, 4, 1, 1, 1, 3, 2, 2);
        vid_en = 1'b1;
        @(negedge clk);
        check("R8 start next edge", 32'({hsync, vsync}), 32'b11);
        hi_cnt = 0;
        while (hsync === 1'b1 && hi_cnt < 2000) begin
            hi_cnt++;
            @(negedge clk);
        end
        check("R4 saturated ratio", 32'(hi_cnt), 32'd510);

        do_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule